// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block forms the eight-bit status byte of a measurement instrument and raises a service request line towards the controller. It holds three registers: a sticky standard event register, which single-cycle event pulses set, an enable mask for that register, and a mask that chooses which summary bits of the status byte may ask for service. The status byte collects the summary outputs of the operation and questionable status groups, a message-available flag from the response queue, and the masked OR of the event register.

Two read paths return the status byte. The query path shows the live master summary in bit 6. The serial-poll path shows the latched request-service flag in bit 6, and a poll strobe clears that flag. The flag is set once for each rising edge of the master summary and drives the service request output directly. Both masks are loaded through a small write port. The event register is cleared by a read strobe.

Top module: `status_byte_srq`

## Requirements
- R1: After reset, `evt_q`, `ese_q`, `sre_q` and `srq` are 0. With all status inputs low, both status byte outputs are 0.
- R2: In both status byte outputs, bit 7 equals `oper_sum`, bit 4 equals `mav` and bit 3 equals `ques_sum`. Bits 2, 1 and 0 always read 0. These bits change in the same cycle as their inputs.
- R3: A 1 on bit i of `evt_pulse` sets `evt_q[i]` at the next clock edge. The bit stays set until an `evt_rd` strobe. That strobe clears the register at the edge, except for bits pulsed in the same cycle, which end up set.
- R4: Bit 5 of both status byte outputs is the OR over i of `evt_q[i] AND ese_q[i]`.
- R5: A write with `wr_en`=1 loads `wr_data` at the next edge: into `ese_q` when `wr_sel`=0, and into `sre_q` when `wr_sel`=1.
- R6: Bit 6 of the service request mask is ignored. `sre_q[6]` always reads 0, and writing a 1 there cannot produce a master summary.
- R7: The master summary is the OR, over all bits except bit 6, of status byte AND `sre_q`. Bit 6 of `stb_query` shows it in the same cycle.
- R8: At the clock edge where the master summary is 1 but was 0 at the previous edge, the request flag becomes 1. `srq` and bit 6 of `stb_spoll` show the flag. The flag is not set again while the master summary stays 1.
- R9: `spoll_rd` clears the request flag at the next edge. A rising master summary in the same cycle takes priority, and the flag is then set.
- R10: `stb_spoll` and `stb_query` are equal in every bit except bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mask register write strobe |
| wr_sel | input | 1 | 0 selects the event enable mask, 1 selects the service request mask |
| wr_data | input | 8 | Write data |
| evt_pulse | input | 8 | Single-cycle event pulses, one per event bit |
| evt_rd | input | 1 | Event register read strobe; clears the register |
| oper_sum | input | 1 | Operation group summary |
| ques_sum | input | 1 | Questionable group summary |
| mav | input | 1 | Response queue holds an unread message |
| spoll_rd | input | 1 | Serial poll strobe; clears the request flag |
| evt_q | output | 8 | Standard event register |
| ese_q | output | 8 | Event enable mask |
| sre_q | output | 8 | Service request mask (bit 6 is always 0) |
| stb_query | output | 8 | Status byte with master summary in bit 6 |
| stb_spoll | output | 8 | Status byte with request flag in bit 6 |
| srq | output | 1 | Service request line |

## Verification
The assertions take the summary inputs, `mav` and the strobes to be clean, synchronous levels that settle before each clock edge. They expect `evt_pulse` bits to last one cycle per event. They allow a poll strobe and a rising master summary to coincide. The bench therefore changes inputs only just after the falling edge and holds each strobe for exactly one cycle. Its sweeps run over every mask value against every combination of the summary inputs, both with the event summary active and without it.

// File: rtl/status_byte_srq.sv
module status_byte_srq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic [7:0] evt_pulse,
  input  logic       evt_rd,
  input  logic       oper_sum,
  input  logic       ques_sum,
  input  logic       mav,
  input  logic       spoll_rd,
  output logic [7:0] evt_q,
  output logic [7:0] ese_q,
  output logic [7:0] sre_q,
  output logic [7:0] stb_query,
  output logic [7:0] stb_spoll,
  output logic       srq
);

  localparam logic [7:0] NO_B6 = 8'hBF;

  logic [7:0] sbase;
  logic       esb, mss, mss_d, rqs;

  assign esb       = |(evt_q & ese_q);
  assign sbase     = {oper_sum, 1'b0, esb, mav, ques_sum, 3'b000};
  assign mss       = |(sbase & sre_q & NO_B6);
  assign stb_query = sbase | {1'b0, mss, 6'b0};
  assign stb_spoll = sbase | {1'b0, rqs, 6'b0};
  assign srq       = rqs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      ese_q <= '0;
      sre_q <= '0;
      mss_d <= 1'b0;
      rqs   <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) ese_q <= wr_data;
      if (wr_en &&  wr_sel) sre_q <= wr_data & NO_B6;
      evt_q <= (evt_rd ? 8'h00 : evt_q) | evt_pulse;
      mss_d <= mss;
      if (mss && !mss_d) rqs <= 1'b1;
      else if (spoll_rd) rqs <= 1'b0;
    end
  end

  p_rqs_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mss) |=> srq);

  p_poll_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spoll_rd && !$rose(mss) && $past(rst_n)) |=> !srq);

  p_evt_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rd |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  p_evt_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_sre_b6_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> !sre_q[6]);

  p_paths_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_spoll & NO_B6) == (stb_query & NO_B6));

endmodule

// File: tb/status_byte_srq_bench.sv
module status_byte_srq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0, evt_pulse = '0;
  logic       evt_rd = 1'b0, oper_sum = 1'b0, ques_sum = 1'b0, mav = 1'b0, spoll_rd = 1'b0;
  logic [7:0] evt_q, ese_q, sre_q, stb_query, stb_spoll;
  logic       srq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  status_byte_srq u_status_byte_srq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_pulse(evt_pulse), .evt_rd(evt_rd), .oper_sum(oper_sum), .ques_sum(ques_sum),
    .mav(mav), .spoll_rd(spoll_rd), .evt_q(evt_q), .ese_q(ese_q), .sre_q(sre_q),
    .stb_query(stb_query), .stb_spoll(stb_spoll), .srq(srq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic poll();
    spoll_rd = 1'b1;
    step();
    spoll_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] acc, base, ex;
    logic ms;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 evt", evt_q, 8'h00);
    chk("R1 ese", ese_q, 8'h00);
    chk("R1 sre", sre_q, 8'h00);
    chk("R1 srq", {7'b0, srq}, 8'h00);
    chk("R1 query", stb_query, 8'h00);
    chk("R1 spoll", stb_spoll, 8'h00);

    // R3 sticky event bits
    acc = 8'h00;
    for (int i = 0; i < 8; i++) begin
      evt_pulse = 8'h01 << i;
      step();
      evt_pulse = 8'h00;
      acc |= 8'h01 << i;
      chk("R3 set", evt_q, acc);
    end
    step(); step();
    chk("R3 hold", evt_q, 8'hFF);
    evt_rd = 1'b1;
    #1 chk("R3 during read", evt_q, 8'hFF);
    step();
    evt_rd = 1'b0;
    chk("R3 cleared", evt_q, 8'h00);
    evt_pulse = 8'h0F; step(); evt_pulse = 8'h00;
    evt_rd = 1'b1; evt_pulse = 8'h30; step(); evt_rd = 1'b0; evt_pulse = 8'h00;
    chk("R3 pulse beats read", evt_q, 8'h30);
    evt_rd = 1'b1; step(); evt_rd = 1'b0;

    // R4 and R5: event summary over all enable masks
    evt_pulse = 8'hA5; step(); evt_pulse = 8'h00;
    for (int v = 0; v < 256; v++) begin
      wr(1'b0, 8'(v));
      chk("R5 ese", ese_q, 8'(v));
      chk("R4 esb", {7'b0, stb_query[5]}, {7'b0, |(8'(v) & 8'hA5)});
    end

    // R2, R4, R6, R7, R10: every mask value against every input combination
    for (int e = 0; e < 2; e++) begin
      wr(1'b0, e[0] ? 8'h01 : 8'h00);
      for (int s = 0; s < 256; s++) begin
        wr(1'b1, 8'(s));
        chk("R6 sre", sre_q, 8'(s) & 8'hBF);
        for (int st = 0; st < 8; st++) begin
          oper_sum = st[2]; ques_sum = st[1]; mav = st[0];
          #1;
          base = {st[2], 1'b0, e[0], st[0], st[1], 3'b000};
          ms = |(base & 8'(s) & 8'hBF);
          chk("R2 R7 query", stb_query, base | {1'b0, ms, 6'b0});
          chk("R10 spoll", stb_spoll & 8'hBF, base);
          step();
        end
      end
    end
    oper_sum = 0; ques_sum = 0; mav = 0;
    wr(1'b0, 8'h00);
    step(); poll();

    // R8 and R9: request flag
    wr(1'b1, 8'h10);
    step();
    chk("R8 idle", {7'b0, srq}, 8'h00);
    mav = 1'b1;
    #1;
    chk("R7 live", {7'b0, stb_query[6]}, 8'h01);
    chk("R8 not yet", {7'b0, srq}, 8'h00);
    step();
    chk("R8 set", {7'b0, srq}, 8'h01);
    chk("R8 spoll b6", stb_spoll, 8'h50);
    poll();
    chk("R9 cleared", {7'b0, srq}, 8'h00);
    chk("R10 query b6", stb_query, 8'h50);
    chk("R10 spoll b6", stb_spoll, 8'h10);
    step(); step();
    chk("R8 no reset while high", {7'b0, srq}, 8'h00);
    mav = 1'b0; step();
    mav = 1'b1; spoll_rd = 1'b1; step(); spoll_rd = 1'b0;
    chk("R9 rise beats poll", {7'b0, srq}, 8'h01);
    poll();
    wr(1'b1, 8'h90);
    oper_sum = 1'b1; step(); step();
    chk("R8 no new edge", {7'b0, srq}, 8'h00);
    mav = 1'b0; oper_sum = 1'b0; step();
    wr(1'b1, 8'h10);
    oper_sum = 1'b1; step(); step();
    chk("R7 masked source", {7'b0, srq}, 8'h00);

    // R6 bit 6 ignored
    wr(1'b1, 8'h40);
    chk("R6 b6 write", sre_q, 8'h00);
    oper_sum = 1'b1; ques_sum = 1'b1; mav = 1'b1;
    step(); step();
    chk("R6 no summary", {7'b0, stb_query[6]}, 8'h00);
    chk("R6 no request", {7'b0, srq}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule